// File: doc/BRIEF.md
# Receive ring buffer frame writer

This block takes received Ethernet frames, one byte per cycle, and lays them into a circular byte buffer held in host memory. It drives that memory through a plain synchronous byte write port. Each stored frame is placed behind a 4-byte slot that carries the frame's status word and length. The block streams the payload behind that slot first. Only after the last byte has arrived does it fill the slot in, from a saved start offset. The start of the next frame is then rounded up to a 4-byte boundary.

The host drains the ring by writing its read position into a pointer register. By convention the value it writes is 16 less than its real position, and the block adds the bias back before it compares pointers. The block stores a frame only when the whole frame, slot and padding included, fits into the free space. Otherwise it discards the frame, leaves its write position where it was and pulses an overflow interrupt. Every good frame that is stored gives a one-cycle receive-OK pulse. A buffer-empty flag shows when the write position and the host position coincide.

Top module: `rx_ring_writer`

## Requirements
- R1: The ring size is 8192 shifted left by `size_sel`, for `size_sel` 0, 1 or 2. Every address the block writes is taken modulo that size.
- R2: For each stored frame a 32-bit little-endian word is written at the frame's start offset. Bits 15:0 hold the status and bits 31:16 hold the byte count of the frame including FCS. The 4 bytes go out after the last data byte.
- R3: Data byte i of a frame (counting from 0) is written at (start + 4 + i) modulo the ring size.
- R4: After a stored frame of length L, the next start offset is (start + L + 4 + 3) with bits 1:0 cleared, modulo the ring size.
- R5: Status bit 1 copies `in_align_err`, bit 2 copies `in_crc_err` and bit 5 copies `in_sym_err`, each sampled with the last byte. Bit 0 is set only when bits 1 to 5 are all clear.
- R6: Status bit 4 is set when L < 60 and bit 3 is set when L > 1518. Frames with error bits set are still stored.
- R7: `in_kind` sets one status bit. The codes are 0 = physical-address match (bit 14), 1 = broadcast (bit 13), 2 = multicast (bit 15) and 3 = no bit.
- R8: The host position is the `rdptr_data` value last written plus 16, modulo the ring size. It takes effect from the cycle after the write. Reset loads a value that makes the host position 0.
- R9: `buf_empty` is high exactly when the write position equals the host position. It is high after reset.
- R10: A frame is stored only if (L + 7) with bits 1:0 cleared is strictly less than the free space. The free space is the whole ring when empty, else (host − write) modulo size. Otherwise the block writes no slot word, leaves the write position unchanged and pulses `irq_ovf` for one cycle.
- R11: `irq_rok` pulses for one cycle after each stored frame whose status bit 0 is set, and stays low for frames that are stored with errors or dropped.
- R12: `in_ready` is low for the 4 slot-writing cycles that follow the last byte of a stored frame, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_sel | input | 2 | Ring size index (0..2) |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of the frame |
| in_crc_err | input | 1 | FCS mismatch, sampled with last byte |
| in_align_err | input | 1 | Alignment error, sampled with last byte |
| in_sym_err | input | 1 | Line symbol error, sampled with last byte |
| in_kind | input | 2 | Destination kind, sampled with last byte |
| in_ready | output | 1 | Block accepts bytes |
| rdptr_wr | input | 1 | Host pointer register write strobe |
| rdptr_data | input | 16 | Host read position minus 16 |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | 15 | Memory byte offset in the ring |
| mem_wdata | output | 8 | Memory write byte |
| buf_empty | output | 1 | Write position equals host position |
| irq_ovf | output | 1 | One-cycle pulse: frame dropped for lack of space |
| irq_rok | output | 1 | One-cycle pulse: good frame stored |

## Verification
Two functions can fall in one cycle: a host pointer write and the space decision made on a frame's last byte. The bench provokes this by filling the ring until a 172-byte frame needs exactly the remaining space. It then writes a pointer that frees the whole ring on that frame's last byte. The frame must still be dropped, because the decision uses the pointer as it stood. The ring must then read empty, and the next identical frame must be stored at the unchanged write position.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [0:0] {S_RX = 1'b0, S_SLOT = 1'b1} rxw_state_e;

  localparam int ST_OK    = 0;
  localparam int ST_ALIGN = 1;
  localparam int ST_CRC   = 2;
  localparam int ST_LONG  = 3;
  localparam int ST_RUNT  = 4;
  localparam int ST_SYM   = 5;
  localparam int ST_BCAST = 13;
  localparam int ST_PHYS  = 14;
  localparam int ST_MCAST = 15;

  localparam logic [1:0] K_PHYS  = 2'd0;
  localparam logic [1:0] K_BCAST = 2'd1;
  localparam logic [1:0] K_MCAST = 2'd2;

  localparam int MIN_LEN  = 60;
  localparam int MAX_LEN  = 1518;
  localparam int PTR_BIAS = 16;
  localparam int SLOT_B   = 4;
endpackage

// File: rtl/rxw_ring_geom.sv
module rxw_ring_geom #(
  parameter int BASE_LOG2 = 13,
  parameter int SEL_MAX   = 2,
  parameter int ADDR_W    = BASE_LOG2 + SEL_MAX,
  parameter int HP_W      = 16
) (
  input  logic [1:0]        size_sel,
  input  logic [HP_W-1:0]   host_ptr,
  input  logic [ADDR_W-1:0] wr_pos,
  output logic [ADDR_W-1:0] mask,
  output logic [ADDR_W:0]   free_bytes,
  output logic              empty
);
  import rxw_pkg::*;
  localparam int NSIZES = SEL_MAX + 1;

  logic [ADDR_W-1:0] mask_tab [NSIZES];
  logic [1:0]        sel_eff;
  logic [HP_W-1:0]   biased;
  logic [ADDR_W-1:0] rd_pos;
  logic [ADDR_W-1:0] diff;

  for (genvar g = 0; g < NSIZES; g++) begin : g_size
    localparam logic [ADDR_W:0] TOP_BIT = (ADDR_W+1)'(1) << (BASE_LOG2 + g);
    assign mask_tab[g] = TOP_BIT[ADDR_W-1:0] - ADDR_W'(1);
  end

  always_comb begin
    sel_eff = (size_sel > 2'(SEL_MAX)) ? 2'(SEL_MAX) : size_sel;
    mask    = mask_tab[0];
    for (int i = 0; i < NSIZES; i++) begin
      if (sel_eff == 2'(i)) mask = mask_tab[i];
    end
  end

  always_comb begin
    biased     = host_ptr + HP_W'(PTR_BIAS);
    rd_pos     = biased[ADDR_W-1:0] & mask;
    empty      = (rd_pos == wr_pos);
    diff       = (rd_pos - wr_pos) & mask;
    free_bytes = empty ? ({1'b0, mask} + (ADDR_W+1)'(1)) : {1'b0, diff};
  end
endmodule

// File: rtl/rxw_status_gen.sv
module rxw_status_gen #(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0] len,
  input  logic             crc_err,
  input  logic             align_err,
  input  logic             sym_err,
  input  logic [1:0]       kind,
  output logic [15:0]      status
);
  import rxw_pkg::*;

  always_comb begin
    status            = '0;
    status[ST_ALIGN]  = align_err;
    status[ST_CRC]    = crc_err;
    status[ST_SYM]    = sym_err;
    status[ST_RUNT]   = (len < LEN_W'(MIN_LEN));
    status[ST_LONG]   = (len > LEN_W'(MAX_LEN));
    case (kind)
      K_PHYS:  status[ST_PHYS]  = 1'b1;
      K_BCAST: status[ST_BCAST] = 1'b1;
      K_MCAST: status[ST_MCAST] = 1'b1;
      default: ;
    endcase
    status[ST_OK] = ~|status[ST_SYM:ST_ALIGN];
  end
endmodule

// File: rtl/rxw_ctrl.sv
module rxw_ctrl #(
  parameter int ADDR_W = 15,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [ADDR_W-1:0] mask,
  input  logic [ADDR_W:0]   free_bytes,
  input  logic [15:0]       status,
  output logic [LEN_W-1:0]  len_fin,
  output logic [ADDR_W-1:0] wptr,
  output logic              in_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              irq_ovf,
  output logic              irq_rok
);
  import rxw_pkg::*;
  localparam int CW = LEN_W + 2;

  rxw_state_e        state_q, state_n;
  logic [LEN_W-1:0]  cnt_q, cnt_n;
  logic              drop_q, drop_n;
  logic [1:0]        idx_q, idx_n;
  logic [31:0]       slot_q, slot_n;
  logic [ADDR_W-1:0] nxt_q, nxt_n;
  logic              ok_q, ok_n;
  logic [ADDR_W-1:0] wptr_q, wptr_n;
  logic              we_q, we_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [7:0]        wd_q, wd_n;
  logic              ovf_q, ovf_n, rok_q, rok_n;

  logic [CW-1:0]     byte_end;
  logic [CW-1:0]     need;
  logic [CW-1:0]     free_x;
  logic              byte_fits;
  logic              frame_fits;
  logic [LEN_W-1:0]  cnt_inc;
  logic [CW-1:0]     dat_off;
  logic [CW-1:0]     nxt_sum;
  logic [ADDR_W-1:0] slot_off;

  always_comb begin
    cnt_inc    = (&cnt_q) ? cnt_q : cnt_q + LEN_W'(1);
    len_fin    = cnt_inc;
    free_x     = CW'(free_bytes);
    byte_end   = CW'(cnt_q) + CW'(SLOT_B + 1);
    byte_fits  = (byte_end < free_x);
    need       = (CW'(len_fin) + CW'(SLOT_B + 3)) & ~CW'(3);
    frame_fits = !drop_q && byte_fits && (need < free_x);
    dat_off    = CW'(wptr_q) + CW'(SLOT_B) + CW'(cnt_q);
    nxt_sum    = CW'(wptr_q) + need;
    slot_off   = (wptr_q + ADDR_W'(idx_q)) & mask;
  end

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    drop_n  = drop_q;
    idx_n   = idx_q;
    slot_n  = slot_q;
    nxt_n   = nxt_q;
    ok_n    = ok_q;
    wptr_n  = wptr_q;
    we_n    = 1'b0;
    addr_n  = addr_q;
    wd_n    = wd_q;
    ovf_n   = 1'b0;
    rok_n   = 1'b0;
    case (state_q)
      S_RX: begin
        if (in_valid) begin
          if (!drop_q && byte_fits) begin
            we_n   = 1'b1;
            addr_n = dat_off[ADDR_W-1:0] & mask;
            wd_n   = in_data;
          end
          drop_n = drop_q | !byte_fits;
          cnt_n  = cnt_inc;
          if (in_last) begin
            cnt_n  = '0;
            drop_n = 1'b0;
            if (frame_fits) begin
              state_n = S_SLOT;
              idx_n   = 2'd0;
              slot_n  = {len_fin, status};
              nxt_n   = nxt_sum[ADDR_W-1:0] & mask;
              ok_n    = status[ST_OK];
            end else begin
              ovf_n = 1'b1;
            end
          end
        end
      end
      S_SLOT: begin
        we_n   = 1'b1;
        addr_n = slot_off;
        wd_n   = slot_q[8*idx_q +: 8];
        idx_n  = idx_q + 2'd1;
        if (idx_q == 2'd3) begin
          state_n = S_RX;
          wptr_n  = nxt_q;
          rok_n   = ok_q;
        end
      end
      default: state_n = S_RX;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_RX;
      cnt_q   <= '0;
      drop_q  <= 1'b0;
      idx_q   <= '0;
      slot_q  <= '0;
      nxt_q   <= '0;
      ok_q    <= 1'b0;
      wptr_q  <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wd_q    <= '0;
      ovf_q   <= 1'b0;
      rok_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      drop_q  <= drop_n;
      idx_q   <= idx_n;
      slot_q  <= slot_n;
      nxt_q   <= nxt_n;
      ok_q    <= ok_n;
      wptr_q  <= wptr_n;
      we_q    <= we_n;
      addr_q  <= addr_n;
      wd_q    <= wd_n;
      ovf_q   <= ovf_n;
      rok_q   <= rok_n;
    end
  end

  assign wptr      = wptr_q;
  assign in_ready  = (state_q == S_RX);
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wd_q;
  assign irq_ovf   = ovf_q;
  assign irq_rok   = rok_q;
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int BASE_LOG2 = 13,
  parameter int SEL_MAX   = 2,
  parameter int HP_W      = 16,
  parameter int LEN_W     = 16,
  localparam int ADDR_W   = BASE_LOG2 + SEL_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        size_sel,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              in_crc_err,
  input  logic              in_align_err,
  input  logic              in_sym_err,
  input  logic [1:0]        in_kind,
  output logic              in_ready,
  input  logic              rdptr_wr,
  input  logic [HP_W-1:0]   rdptr_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              buf_empty,
  output logic              irq_ovf,
  output logic              irq_rok
);
  import rxw_pkg::*;
  localparam logic [HP_W-1:0] PTR_RST = ~HP_W'(PTR_BIAS - 1);

  logic [HP_W-1:0]   host_ptr_q;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W:0]   free_bytes;
  logic [ADDR_W-1:0] wptr;
  logic [LEN_W-1:0]  len_fin;
  logic [15:0]       status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        host_ptr_q <= PTR_RST;
    else if (rdptr_wr) host_ptr_q <= rdptr_data;
  end

  rxw_ring_geom #(
    .BASE_LOG2(BASE_LOG2), .SEL_MAX(SEL_MAX), .ADDR_W(ADDR_W), .HP_W(HP_W)
  ) u_geom (
    .size_sel(size_sel), .host_ptr(host_ptr_q), .wr_pos(wptr),
    .mask(mask), .free_bytes(free_bytes), .empty(buf_empty)
  );

  rxw_status_gen #(.LEN_W(LEN_W)) u_status (
    .len(len_fin), .crc_err(in_crc_err), .align_err(in_align_err),
    .sym_err(in_sym_err), .kind(in_kind), .status(status)
  );

  rxw_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .mask(mask), .free_bytes(free_bytes), .status(status),
    .len_fin(len_fin), .wptr(wptr), .in_ready(in_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq_ovf(irq_ovf),
    .irq_rok(irq_rok)
  );
endmodule

// File: rtl/rx_ring_writer_checks.sv
module rx_ring_writer_checks #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] wptr,
  input logic              irq_ovf,
  input logic              irq_rok
);
  // R10 / R11: a frame is either dropped or completed, never both
  assert_irq_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_ovf, irq_rok}));

  // R4: frame starts stay 4-byte aligned
  assert_start_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wptr[1:0] == 2'b00);

  // R10: a dropped frame leaves the write position alone
  assert_drop_keeps_wptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> $stable(wptr));

  // R12: every stalled cycle issues one slot byte write
  assert_stall_writes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> mem_we);

  // R2 / R11: completion only follows the slot phase
  assert_rok_after_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rok) |-> $past(!in_ready));
endmodule

bind rx_ring_writer rx_ring_writer_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_we(mem_we),
  .wptr(wptr), .irq_ovf(irq_ovf), .irq_rok(irq_rok)
);

// File: tb/rx_ring_writer_tb.sv
`timescale 1ns/1ps
module rx_ring_writer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  size_sel;
  logic        in_valid, in_last, in_crc_err, in_align_err, in_sym_err;
  logic [7:0]  in_data;
  logic [1:0]  in_kind;
  logic        in_ready;
  logic        rdptr_wr;
  logic [15:0] rdptr_data;
  logic        mem_we;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        buf_empty, irq_ovf, irq_rok;

  always #2 clk = ~clk;

  rx_ring_writer u_dut (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_crc_err(in_crc_err),
    .in_align_err(in_align_err), .in_sym_err(in_sym_err), .in_kind(in_kind),
    .in_ready(in_ready), .rdptr_wr(rdptr_wr), .rdptr_data(rdptr_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .buf_empty(buf_empty), .irq_ovf(irq_ovf), .irq_rok(irq_rok)
  );

  logic [7:0] mem [int];
  int n_chk = 0, n_fail = 0, rok_cnt = 0, ovf_cnt = 0;
  int wptr_m = 0, mask_m = 8191;
  bit done = 0;

  always @(negedge clk) begin
    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    if (irq_rok) rok_cnt++;
    if (irq_ovf) ovf_cnt++;
  end

  // {len[15:0], crc, align, sym, kind[1:0]}
  localparam int NV = 11;
  localparam bit [20:0] VEC [NV] = '{
    {16'd64,   1'b0, 1'b0, 1'b0, 2'd0},
    {16'd60,   1'b0, 1'b0, 1'b0, 2'd1},
    {16'd59,   1'b0, 1'b0, 1'b0, 2'd0},
    {16'd1518, 1'b0, 1'b0, 1'b0, 2'd2},
    {16'd1519, 1'b0, 1'b0, 1'b0, 2'd0},
    {16'd61,   1'b0, 1'b0, 1'b0, 2'd3},
    {16'd100,  1'b1, 1'b0, 1'b0, 2'd0},
    {16'd77,   1'b0, 1'b1, 1'b0, 2'd1},
    {16'd90,   1'b0, 1'b0, 1'b1, 2'd2},
    {16'd62,   1'b0, 1'b0, 1'b0, 2'd1},
    {16'd63,   1'b0, 1'b0, 1'b0, 2'd2}
  };

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int exp_status(int len, bit crc, bit al, bit sym, bit [1:0] kind);
    int s = 0;
    if (al)        s |= 1 << 1;
    if (crc)       s |= 1 << 2;
    if (len > 1518) s |= 1 << 3;
    if (len < 60)  s |= 1 << 4;
    if (sym)       s |= 1 << 5;
    if (kind == 2'd0) s |= 1 << 14;
    if (kind == 2'd1) s |= 1 << 13;
    if (kind == 2'd2) s |= 1 << 15;
    if ((s & 32'h3e) == 0) s |= 1;
    return s;
  endfunction

  function automatic int rd_mem(int a);
    if (mem.exists(a & mask_m)) return int'(mem[a & mask_m]);
    return 32'h1ff;
  endfunction

  task automatic do_reset(input logic [1:0] sel);
    rst_n = 1'b0; size_sel = sel; in_valid = 0; in_last = 0; in_data = 0;
    in_crc_err = 0; in_align_err = 0; in_sym_err = 0; in_kind = 0;
    rdptr_wr = 0; rdptr_data = 0;
    mem.delete();
    wptr_m = 0; mask_m = (8192 << sel) - 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic consume(input string tag);
    rdptr_wr = 1'b1; rdptr_data = 16'((wptr_m - 16) & 16'hffff);
    @(negedge clk); rdptr_wr = 1'b0;
    @(negedge clk);
    check(buf_empty == 1'b1, {tag, " buf_empty after host catch-up"}, buf_empty, 1);
  endtask

  task automatic frame(input int len, input bit crc, input bit al, input bit sym,
                       input bit [1:0] kind, input int seed, input bit acc,
                       input bit host_wr, input string tag);
    int r0 = rok_cnt, o0 = ovf_cnt, st, word, bad;
    st = exp_status(len, crc, al, sym, kind);
    while (!in_ready) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      in_valid = 1; in_data = 8'((seed * 7 + i) & 255); in_last = (i == len - 1);
      in_crc_err = crc; in_align_err = al; in_sym_err = sym; in_kind = kind;
      if (host_wr && i == len - 1) begin
        rdptr_wr = 1; rdptr_data = 16'((wptr_m - 16) & 16'hffff);
      end
      @(negedge clk);
      rdptr_wr = 0;
    end
    in_valid = 0; in_last = 0;
    if (acc) check(in_ready == 1'b0, {tag, " R12 in_ready low after last"}, in_ready, 0);
    repeat (8) @(negedge clk);
    check(in_ready == 1'b1, {tag, " R12 in_ready back high"}, in_ready, 1);
    if (acc) begin
      word = rd_mem(wptr_m) | (rd_mem(wptr_m + 1) << 8) |
             (rd_mem(wptr_m + 2) << 16) | (rd_mem(wptr_m + 3) << 24);
      check(word == ((len << 16) | st), {tag, " R2/R5/R6/R7 slot word"}, word, (len << 16) | st);
      bad = 0;
      for (int i = 0; i < len; i++)
        if (rd_mem(wptr_m + 4 + i) != ((seed * 7 + i) & 255)) bad++;
      check(bad == 0, {tag, " R1/R3 payload bytes"}, bad, 0);
      check(rok_cnt - r0 == (st & 1), {tag, " R11 rok pulses"}, rok_cnt - r0, st & 1);
      check(ovf_cnt == o0, {tag, " R10 no overflow"}, ovf_cnt - o0, 0);
      wptr_m = (wptr_m + len + 4 + 3) & ~3 & mask_m;
    end else begin
      check(ovf_cnt - o0 == 1, {tag, " R10 overflow pulse"}, ovf_cnt - o0, 1);
      check(rok_cnt == r0, {tag, " R11 no rok on drop"}, rok_cnt - r0, 0);
    end
  endtask

  initial begin
    do_reset(2'd0);
    check(buf_empty == 1'b1, "R9 empty after reset", buf_empty, 1);
    check(in_ready == 1'b1, "R12 ready after reset", in_ready, 1);
    check(irq_rok == 1'b0 && irq_ovf == 1'b0, "R11 irqs idle after reset", {irq_rok, irq_ovf}, 0);
    check(mem_we == 1'b0, "R8 no write after reset", mem_we, 0);

    for (int v = 0; v < NV; v++) begin
      frame(int'(VEC[v][20:5]), VEC[v][4], VEC[v][3], VEC[v][2], VEC[v][1:0], v + 1,
            1'b1, 1'b0, $sformatf("vec%0d", v));
      check(buf_empty == 1'b0, "R9 not empty after store", buf_empty, 0);
      consume("R4/R8");
    end

    // fill: four 2000-byte frames leave 176 free bytes (ring wraps, R1)
    for (int k = 0; k < 4; k++)
      frame(2000, 0, 0, 0, 2'd0, 20 + k, 1'b1, 1'b0, "fill");
    frame(172, 0, 0, 0, 2'd0, 30, 1'b0, 1'b0, "R10 need==free");
    // host frees the ring in the same cycle as the decision: still dropped (R8)
    frame(172, 0, 0, 0, 2'd0, 31, 1'b0, 1'b1, "R8 same-cycle host write");
    check(buf_empty == 1'b1, "R8/R9 empty after late host write", buf_empty, 1);
    frame(172, 0, 0, 0, 2'd0, 32, 1'b1, 1'b0, "R10 fits after drain");
    consume("R4");

    // 16 KB ring: addresses run past 8191
    do_reset(2'd1);
    for (int k = 0; k < 6; k++) begin
      frame(1500, 0, 0, 0, 2'd1, 40 + k, 1'b1, 1'b0, "R1 16K");
      consume("R1/R4");
    end
    check(wptr_m > 8192, "R1 write position beyond 8 KB", wptr_m, 9024);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule